// File: doc/BRIEF.md
# Multiplexed-Strobe Memory Command Decoder

This block is the device side of a memory port that takes its address in two halves, framed by a row strobe and a column strobe. The block runs on a clock and samples the strobes, the write and output-enable controls, the address pins and the write data. All of these are active-low at the pins. From the order in which the strobes become active, the block decides which kind of access each strobe cycle is. It can be a read, an early write, a read-modify-write, a refresh of the row on the pins, a refresh that uses the internal row counter, or a hidden refresh that runs while read data is still shown. The block latches the row and column halves and accesses a small synchronous array. A memory controller can then be run in a loop against it, with no analog model behind it.

Every decided cycle appears for one clock on an event output. The event carries a kind code and a row value: the latched row for accesses and row-pin refreshes, and the counter value for counter refreshes. Read data stays on the output after the column strobe is released, in the extended-data-out manner. The output is released only when both strobes are inactive, when output enable is deasserted, or when write enable is asserted.

Top module: `dram_strobe_decoder`

## Requirements
- R1: After reset the data output is not driven (`dq_oe` = 0), no event is flagged, and the refresh row counter holds 0.
- R2: A row strobe that becomes active while the column strobe is inactive latches the row from `addr`. The following column strobe latches the column. With write enable inactive, the word at index {row, col} appears on `dq_out`, with `dq_oe` = 1 while output enable is asserted. When the column strobe is released, an event of kind 1 (read) is raised, carrying the row.
- R3: If write enable is already active when the column strobe is sampled active, `dq_in` is written to {row, col} and an event of kind 2 (early write) is raised with the row. `dq_oe` stays 0 for that whole access.
- R4: If write enable becomes active during a read column access, the old word is driven first. After that `dq_oe` drops, the current `dq_in` is written to the same location, and an event of kind 3 (read-modify-write) is raised with the row.
- R5: A row strobe pulse with no column strobe during it raises an event of kind 4 (row-pin refresh) whose row field is the row latched from `addr`. `dq_oe` stays 0 and the array contents are not changed.
- R6: If the column strobe was already active in the sample before the row strobe becomes active, an event of kind 5 (counter refresh) is raised with the current counter value. The counter then advances by one, modulo 2^REF_W. No address is used and the array is not changed.
- R7: After a read, the row strobe may be released and asserted again while the column strobe stays active. This raises a read event and then an event of kind 6 (hidden refresh) with the counter value, and the counter advances. The read word stays on `dq_out` with `dq_oe` = 1 throughout.
- R8: `dq_oe` goes to 0 once both strobes are inactive, once output enable is deasserted, or once write enable is asserted.
- R9: Releasing the column strobe while the row strobe stays active keeps the last read word driven. A further column strobe in the same row reads the word at the new column.
- R10: If the row and column strobes first appear active in the same sample, the row strobe is taken as first. The cycle is a normal access and not a counter refresh, and the counter does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | DQ_W | Write data |
| dq_out | output | DQ_W | Read data, held between accesses |
| dq_oe | output | 1 | Read data drive enable |
| evt_valid | output | 1 | One-cycle flag for a classified cycle |
| evt_kind | output | 3 | 1 read, 2 early write, 3 read-modify-write, 4 row-pin refresh, 5 counter refresh, 6 hidden refresh |
| evt_row | output | REF_W | Row of the access, or counter value for counter refreshes |

## Verification
On every cycle, the assertions check the output release rules: a write enable, a deasserted output enable or two idle strobes must each leave `dq_oe` low a cycle later. They also check that early writes and row-pin refreshes never coincide with a driven output, that each counter refresh reports the value just before the counter's step, and that the array is never read and written in the same cycle. Only the bench scenarios can show the effects that depend on strobe ordering and stored data. These include the data read back after early and read-modify-write cycles, the data that stays driven across page steps and hidden refresh, the counter sequence across mixed refresh kinds, and the same-sample tie going to the row strobe.

// File: rtl/dram_dec_pkg.sv
package dram_dec_pkg;

  typedef enum logic [2:0] {
    EVT_NONE   = 3'd0,
    EVT_READ   = 3'd1,
    EVT_EWRITE = 3'd2,
    EVT_RMW    = 3'd3,
    EVT_ROWREF = 3'd4,
    EVT_CNTREF = 3'd5,
    EVT_HIDDEN = 3'd6
  } evt_kind_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_RD,
    ST_WR,
    ST_HOLD,
    ST_REF
  } dec_state_t;

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);

  logic [W-1:0] stage1;

  // two sampling stages plus one older copy for edge ordering
  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
      q_prev <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
      q_prev <= q;
    end
  end

endmodule

// File: rtl/cell_array.sv
module cell_array #(
  parameter int AW = 8,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end

  p_port_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && rd_en));

endmodule

// File: rtl/cycle_fsm.sv
module cycle_fsm
  import dram_dec_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DQ_W   = 4,
  parameter int REF_W  = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ras,
  input  logic                cas,
  input  logic                cas_prev,
  input  logic                we,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DQ_W-1:0]     din,
  output logic                wr_en,
  output logic [2*ADDR_W-1:0] wr_addr,
  output logic [DQ_W-1:0]     wr_data,
  output logic                rd_en,
  output logic [2*ADDR_W-1:0] rd_addr,
  output logic                evt_valid,
  output logic [2:0]          evt_kind,
  output logic [REF_W-1:0]    evt_row
);

  localparam int PAD_W = REF_W - ADDR_W;

  dec_state_t         st;
  logic [ADDR_W-1:0]  row_q;
  logic [ADDR_W-1:0]  col_q;
  logic               col_seen;
  logic [REF_W-1:0]   ref_cnt;
  logic [REF_W-1:0]   row_ext;

  assign row_ext = {{PAD_W{1'b0}}, row_q};

  always_ff @(posedge clk) begin
    evt_valid <= 1'b0;
    wr_en     <= 1'b0;
    rd_en     <= 1'b0;
    if (rst) begin
      st       <= ST_IDLE;
      row_q    <= '0;
      col_q    <= '0;
      col_seen <= 1'b0;
      ref_cnt  <= '0;
      evt_kind <= EVT_NONE;
      evt_row  <= '0;
    end else begin
      case (st)
        ST_IDLE: if (ras) begin
          if (cas_prev) begin
            evt_valid <= 1'b1;
            evt_kind  <= EVT_CNTREF;
            evt_row   <= ref_cnt;
            ref_cnt   <= ref_cnt + 1'b1;
            st        <= ST_REF;
          end else begin
            row_q    <= addr;
            col_seen <= 1'b0;
            st       <= ST_ROW;
          end
        end
        ST_ROW: begin
          if (!ras) begin
            if (!col_seen) begin
              evt_valid <= 1'b1;
              evt_kind  <= EVT_ROWREF;
              evt_row   <= row_ext;
            end
            st <= ST_IDLE;
          end else if (cas) begin
            col_seen <= 1'b1;
            col_q    <= addr;
            if (we) begin
              wr_en     <= 1'b1;
              wr_addr   <= {row_q, addr};
              wr_data   <= din;
              evt_valid <= 1'b1;
              evt_kind  <= EVT_EWRITE;
              evt_row   <= row_ext;
              st        <= ST_WR;
            end else begin
              rd_en   <= 1'b1;
              rd_addr <= {row_q, addr};
              st      <= ST_RD;
            end
          end
        end
        ST_RD: begin
          if (we) begin
            wr_en     <= 1'b1;
            wr_addr   <= {row_q, col_q};
            wr_data   <= din;
            evt_valid <= 1'b1;
            evt_kind  <= EVT_RMW;
            evt_row   <= row_ext;
            st        <= ST_WR;
          end else if (!cas || !ras) begin
            evt_valid <= 1'b1;
            evt_kind  <= EVT_READ;
            evt_row   <= row_ext;
            if (ras)      st <= ST_ROW;
            else if (cas) st <= ST_HOLD;
            else          st <= ST_IDLE;
          end
        end
        ST_WR: begin
          if (!ras)      st <= cas ? ST_HOLD : ST_IDLE;
          else if (!cas) st <= ST_ROW;
        end
        ST_HOLD: begin
          if (ras) begin
            evt_valid <= 1'b1;
            evt_kind  <= EVT_HIDDEN;
            evt_row   <= ref_cnt;
            ref_cnt   <= ref_cnt + 1'b1;
            st        <= ST_REF;
          end else if (!cas) begin
            st <= ST_IDLE;
          end
        end
        ST_REF: if (!ras) st <= cas ? ST_HOLD : ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R6 / R7: a refresh event reports the value the counter held before its step
  p_cnt_step_r6: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && (evt_kind == EVT_CNTREF || evt_kind == EVT_HIDDEN))
      |-> (REF_W'(evt_row + 1'b1) == ref_cnt));

endmodule

// File: rtl/dram_strobe_decoder.sv
module dram_strobe_decoder
  import dram_dec_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DQ_W   = 4,
  parameter int REF_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DQ_W-1:0]   dq_in,
  output logic [DQ_W-1:0]   dq_out,
  output logic              dq_oe,
  output logic              evt_valid,
  output logic [2:0]        evt_kind,
  output logic [REF_W-1:0]  evt_row
);

  localparam int AW     = 2 * ADDR_W;
  localparam int SYNC_W = 4 + ADDR_W + DQ_W;

  logic [SYNC_W-1:0] raw_vec, s_vec, p_vec;
  logic              ras_s, cas_s, we_s, oe_s, cas_p;
  logic [ADDR_W-1:0] addr_s;
  logic [DQ_W-1:0]   din_s;

  logic              wr_en, rd_en, rd_pend;
  logic [AW-1:0]     wr_addr, rd_addr;
  logic [DQ_W-1:0]   wr_data, rd_data;
  logic              held, held_nx, rel_out;

  // strobes converted to active-high before sampling
  assign raw_vec = {~ras_n, ~cas_n, ~we_n, ~oe_n, addr, dq_in};

  strobe_sync #(.W(SYNC_W)) u_sync (
    .clk(clk), .rst(rst), .d(raw_vec), .q(s_vec), .q_prev(p_vec)
  );

  assign ras_s  = s_vec[SYNC_W-1];
  assign cas_s  = s_vec[SYNC_W-2];
  assign we_s   = s_vec[SYNC_W-3];
  assign oe_s   = s_vec[SYNC_W-4];
  assign addr_s = s_vec[ADDR_W+DQ_W-1:DQ_W];
  assign din_s  = s_vec[DQ_W-1:0];
  assign cas_p  = p_vec[SYNC_W-2];

  cycle_fsm #(.ADDR_W(ADDR_W), .DQ_W(DQ_W), .REF_W(REF_W)) u_fsm (
    .clk(clk), .rst(rst), .ras(ras_s), .cas(cas_s), .cas_prev(cas_p),
    .we(we_s), .addr(addr_s), .din(din_s),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .evt_valid(evt_valid), .evt_kind(evt_kind), .evt_row(evt_row)
  );

  cell_array #(.AW(AW), .DW(DQ_W)) u_array (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // output hold: kept across strobe changes until a release condition
  assign rel_out = (!ras_s && !cas_s) || we_s;

  always_comb begin
    held_nx = held;
    if (rel_out)      held_nx = 1'b0;
    else if (rd_pend) held_nx = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend <= 1'b0;
      held    <= 1'b0;
      dq_oe   <= 1'b0;
      dq_out  <= '0;
    end else begin
      rd_pend <= rd_en;
      held    <= held_nx;
      dq_oe   <= held_nx && oe_s && !we_s;
      if (rd_pend) dq_out <= rd_data;
    end
  end

  p_we_release_r8: assert property (@(posedge clk) disable iff (rst)
    we_s |=> !dq_oe);
  p_oe_release_r8: assert property (@(posedge clk) disable iff (rst)
    !oe_s |=> !dq_oe);
  p_idle_release_r8: assert property (@(posedge clk) disable iff (rst)
    (!ras_s && !cas_s) |=> !dq_oe);
  p_ewrite_open_r3: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_kind == EVT_EWRITE) |-> !dq_oe);
  p_rowref_open_r5: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_kind == EVT_ROWREF) |-> !dq_oe);

endmodule

// File: tb/test_dram_strobe_decoder.sv
module test_dram_strobe_decoder;

  localparam int ADDR_W = 4;
  localparam int DQ_W   = 4;
  localparam int REF_W  = 12;
  localparam int SETTLE = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DQ_W-1:0]   dq_in = '0;
  logic [DQ_W-1:0]   dq_out;
  logic              dq_oe;
  logic              evt_valid;
  logic [2:0]        evt_kind;
  logic [REF_W-1:0]  evt_row;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  logic [REF_W+2:0] exp_q [$];

  always #4 clk = ~clk;

  dram_strobe_decoder #(.ADDR_W(ADDR_W), .DQ_W(DQ_W), .REF_W(REF_W)) i_dram_strobe_decoder (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .evt_valid(evt_valid), .evt_kind(evt_kind), .evt_row(evt_row)
  );

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic expect_evt(input logic [2:0] kind, input int row);
    exp_q.push_back({kind, REF_W'(row)});
  endtask

  task automatic check_out(input string req, input logic exp_oe, input logic [DQ_W-1:0] exp_d);
    n_cmp++;
    if (dq_oe !== exp_oe || (exp_oe && dq_out !== exp_d)) begin
      n_bad++;
      $display("FAIL %s: dq_oe=%0b dq_out=%h expected dq_oe=%0b dq_out=%h",
               req, dq_oe, dq_out, exp_oe, exp_d);
    end
  endtask

  task automatic ras_on(input int row);
    addr = ADDR_W'(row); ras_n = 1'b0; settle();
  endtask
  task automatic ras_off();
    ras_n = 1'b1; settle();
  endtask
  task automatic cas_on(input int col);
    addr = ADDR_W'(col); cas_n = 1'b0; settle();
  endtask
  task automatic cas_off();
    cas_n = 1'b1; settle();
  endtask

  // R3: early write helper
  task automatic early_write(input int row, input int col, input logic [DQ_W-1:0] d);
    we_n = 1'b0; dq_in = d;
    ras_on(row);
    expect_evt(3'd2, row);
    cas_on(col);
    check_out("R3 early write keeps output open", 1'b0, '0);
    cas_off(); ras_off(); we_n = 1'b1;
  endtask

  // R2: single read of one word, closed by both strobes
  task automatic read_word(input string req, input int row, input int col, input logic [DQ_W-1:0] d);
    ras_on(row); cas_on(col);
    check_out(req, 1'b1, d);
    expect_evt(3'd1, row);
    cas_off(); ras_off();
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && evt_valid) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R2 event: got kind=%0d row=%0d expected none", evt_kind, evt_row);
      end else begin
        logic [REF_W+2:0] e;
        e = exp_q.pop_front();
        if (evt_kind !== e[REF_W+2:REF_W] || evt_row !== e[REF_W-1:0]) begin
          n_bad++;
          $display("FAIL R2/R3/R4/R5/R6/R7 event: got kind=%0d row=%0d expected kind=%0d row=%0d",
                   evt_kind, evt_row, e[REF_W+2:REF_W], e[REF_W-1:0]);
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    settle();
    // R1: reset state
    n_cmp++;
    if (dq_oe !== 1'b0 || evt_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: dq_oe=%0b evt_valid=%0b expected 0 0", dq_oe, evt_valid);
    end

    // R6 + R1: counter refresh starts at 0
    cas_on(0);
    expect_evt(3'd5, 0);
    ras_on(0);
    check_out("R6 counter refresh output open", 1'b0, '0);
    ras_off(); cas_off();

    early_write(3, 5, 4'hA);
    early_write(3, 6, 4'h6);
    early_write(7, 2, 4'h9);
    early_write(5, 5, 4'h3);

    // R2 read, R9 page step with held data
    ras_on(3); cas_on(5);
    check_out("R2 read word", 1'b1, 4'hA);
    expect_evt(3'd1, 3);
    cas_off();
    check_out("R9 data held after column release", 1'b1, 4'hA);
    cas_on(6);
    check_out("R9 next column in page", 1'b1, 4'h6);
    // R8: output enable gating
    oe_n = 1'b1; settle();
    check_out("R8 output enable deasserted", 1'b0, '0);
    oe_n = 1'b0; settle();
    check_out("R8 output enable restored", 1'b1, 4'h6);
    expect_evt(3'd1, 3);
    cas_off(); ras_off();
    check_out("R8 both strobes idle", 1'b0, '0);

    // R4 read-modify-write
    ras_on(7); cas_on(2);
    check_out("R4 old data first", 1'b1, 4'h9);
    dq_in = 4'hC;
    expect_evt(3'd3, 7);
    we_n = 1'b0; settle();
    check_out("R4/R8 write enable releases output", 1'b0, '0);
    cas_off(); ras_off(); we_n = 1'b1;
    read_word("R4 new data stored", 7, 2, 4'hC);

    // R5 row-pin refresh
    expect_evt(3'd4, 11);
    ras_on(11);
    check_out("R5 row refresh output open", 1'b0, '0);
    ras_off();
    read_word("R5 array unchanged", 3, 5, 4'hA);

    // R7 hidden refresh
    ras_on(3); cas_on(5);
    expect_evt(3'd1, 3);
    ras_off();
    check_out("R7 data held with row strobe released", 1'b1, 4'hA);
    expect_evt(3'd6, 1);
    ras_on(9);
    check_out("R7 data held during hidden refresh", 1'b1, 4'hA);
    ras_off(); cas_off();
    check_out("R7 output released after hidden refresh", 1'b0, '0);

    // R6 counter advanced
    cas_on(0);
    expect_evt(3'd5, 2);
    ras_on(0);
    ras_off(); cas_off();

    // R10 same-sample strobes: normal access, row taken first
    addr = 4'd5; ras_n = 1'b0; cas_n = 1'b0; settle();
    check_out("R10 same-sample read", 1'b1, 4'h3);
    expect_evt(3'd1, 5);
    cas_off(); ras_off();

    // R10: counter untouched by the tie
    cas_on(0);
    expect_evt(3'd5, 3);
    ras_on(0);
    ras_off(); cas_off();

    settle();
    n_cmp++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R2 events: %0d pending expected 0", exp_q.size());
    end
    finish_run();
  end

endmodule